// File: doc/BRIEF.md
# Cache Flush Sequencer

This block empties a two-way set-associative cache on request from software. Software raises a one-cycle set pulse, and the block holds a flush request flag until it is done. While the flag is high, the block walks the tag/status store one line at a time. It goes up through every index of way 0, then through every index of way 1. For each valid line it asks the bus interface to write back every modified 32-byte sector, lowest sector first, one request at a time. It then writes the line's tag entry back as invalid and clean. After the invalidation write of the last line it drops the flag without software help.

A dropped flag only means the tag store holds no valid lines. Write-backs that were already accepted may still be queued further down the bus path.

While the flag is high, the block signals the instruction side and the data side to hold off their cache requests. Snoop lookups keep full access: a snoop takes the tag port in the cycle it asks for it, and the walk waits. Afterwards the walk resumes at the same line, so no line is skipped or visited twice. The block keeps a copy of the line it is working on. When a snoop cleans or invalidates that line, the copy is updated, so no write-back goes out for data the snoop already removed.

Top module: `cache_flush_sequencer`

## Requirements
- R1: After reset, `flush_req`, `core_block`, `co_req` and `tag_en` are all 0.
- R2: A one-cycle `flush_set` pulse makes `flush_req` read 1 in the following cycle. Write-backs then come out in this order: way 0 before way 1, indices ascending from 0, and sectors ascending inside a line.
- R3: Each dirty sector of a valid line produces exactly one write-back request, with the fields `co_way`, `co_idx` and `co_sec`. `co_req` and these fields stay steady until the cycle in which `co_ack` is high. The one exception is a snoop in that cycle that removes the sector's data.
- R4: An invalid line produces no write-back, even if its dirty bits read 1. A clean sector of a valid line also produces none.
- R5: The walk writes every line's entry as valid=0 with all dirty bits 0. Every write the walk itself makes carries exactly these values, so no valid line remains when the flush ends.
- R6: `core_block` equals `flush_req` in every cycle, and `co_req` is never high while `flush_req` is low.
- R7: `flush_req` returns to 0 by itself, in the clock edge that accepts the invalidation write of the last line (way 1, top index).
- R8: In any cycle with `snp_req` high, the tag port carries the snoop's enable, write flag, way, index and write data. The walk still visits every line exactly once.
- R9: If a snoop write cleans or invalidates a line before the walk has read it, that line gets no write-back for the removed sectors.
- R10: A `flush_set` pulse while `flush_req` is already 1 has no effect: once the running flush completes, no second walk starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_set | input | 1 | Software pulse that raises the flush request flag |
| flush_req | output | 1 | Flush request flag; cleared by hardware when the walk ends |
| core_block | output | 1 | Hold-off to the instruction and data sides of the cache |
| snp_req | input | 1 | Snoop wants the tag port this cycle |
| snp_we | input | 1 | Snoop access is a write |
| snp_way | input | WAY_W | Snoop way |
| snp_idx | input | IDX_W | Snoop index |
| snp_wvalid | input | 1 | Valid bit written by the snoop |
| snp_wdirty | input | SECTORS | Per-sector dirty bits written by the snoop |
| tag_en | output | 1 | Tag store access enable |
| tag_we | output | 1 | Tag store write enable |
| tag_way | output | WAY_W | Tag store way |
| tag_idx | output | IDX_W | Tag store index |
| tag_wvalid | output | 1 | Valid bit to write |
| tag_wdirty | output | SECTORS | Dirty bits to write |
| tag_rvalid | input | 1 | Valid bit read; returned one cycle after the read |
| tag_rdirty | input | SECTORS | Dirty bits read; returned one cycle after the read |
| co_req | output | 1 | Write-back request to the bus interface |
| co_way | output | WAY_W | Way of the sector to write back |
| co_idx | output | IDX_W | Index of the sector to write back |
| co_sec | output | SEC_W | Sector number within the line |
| co_ack | input | 1 | Bus interface accepts the current request |

## Verification
The properties assume the following about the block's neighbours:
- The tag store returns read data exactly one cycle after an enabled read.
- `co_ack` means something only while `co_req` is high.
- A snoop write never sets a dirty bit; it only cleans or invalidates.

The stimulus keeps within these limits:
- A store model in the bench has that one-cycle read latency.
- The acknowledge responder only raises `co_ack` after it has seen a request, with a random delay.
- Snoop writes carry only clean or invalid values.
- Snoop writes target way-1 lines, issued while the walk is still in way 0, so the expected write-back list can be computed before the flush starts.

// File: rtl/cfs_pkg.sv
// Shared types for the cache flush sequencer.
package cfs_pkg;
    // Walk states: wait, read a line, take its entry, write back sectors, invalidate
    typedef enum logic [2:0] {
        WS_IDLE  = 3'd0,
        WS_READ  = 3'd1,
        WS_CAPT  = 3'd2,
        WS_CAST  = 3'd3,
        WS_INVAL = 3'd4
    } walk_state_e;
endpackage

// File: rtl/cfs_walk_counter.sv
// Line pointer of the flush walk.
// Steps the index from 0 to its top value in the current way, then wraps the
// index to 0 and moves to the next way. Assumes WAYS >= 2 and that step is
// never raised on the last line (clr returns the pointer to the start instead).
module cfs_walk_counter #(
    parameter int IDX_W = 4,
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic [WAY_W-1:0] way,
    output logic             last
);
    localparam logic [IDX_W-1:0] IDX_TOP  = '1;
    localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);

    // Advance index first, way on index wrap
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
            way <= '0;
        end else if (step) begin
            if (idx == IDX_TOP) begin
                idx <= '0;
                way <= way + 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // Flag the final line of the final way
    always_comb begin
        last = (idx == IDX_TOP) && (way == WAY_LAST);
    end
endmodule

// File: rtl/cfs_line_hold.sv
// Working copy of the line under flush.
// Loads the valid and dirty bits read from the tag store, clears a sector once
// its write-back is accepted, and merges any snoop write that lands on the same
// line while the copy is live (track high). Dirty bits are kept only while the
// line is valid. Assumes snoop writes never set dirty bits.
module cfs_line_hold #(
    parameter int SECTORS = 2,
    parameter int IDX_W   = 4,
    parameter int WAY_W   = 1,
    parameter int SEC_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               ld_valid,
    input  logic [SECTORS-1:0] ld_dirty,
    input  logic               retire,
    input  logic [SEC_W-1:0]   retire_sec,
    input  logic               track,
    input  logic [WAY_W-1:0]   cur_way,
    input  logic [IDX_W-1:0]   cur_idx,
    input  logic               snp_req,
    input  logic               snp_we,
    input  logic [WAY_W-1:0]   snp_way,
    input  logic [IDX_W-1:0]   snp_idx,
    input  logic               snp_wvalid,
    input  logic [SECTORS-1:0] snp_wdirty,
    output logic [SECTORS-1:0] pend
);
    logic               held_v;
    logic [SECTORS-1:0] held_d;
    logic               nxt_v;
    logic [SECTORS-1:0] nxt_d;
    logic               snp_hit;

    // Detect a snoop write to the line being flushed
    always_comb begin
        snp_hit = track && snp_req && snp_we &&
                  (snp_way == cur_way) && (snp_idx == cur_idx);
        nxt_v   = (load ? ld_valid : held_v) & (snp_hit ? snp_wvalid : 1'b1);
    end

    // Next dirty bit of every sector
    for (genvar s = 0; s < SECTORS; s++) begin : g_sec
        always_comb begin
            nxt_d[s] = (load ? ld_dirty[s] : held_d[s])
                     & ~(retire && (retire_sec == SEC_W'(s)))
                     & (~snp_hit | snp_wdirty[s])
                     & nxt_v;
        end
    end

    // Hold the copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_v <= 1'b0;
            held_d <= '0;
        end else begin
            held_v <= nxt_v;
            held_d <= nxt_d;
        end
    end

    // Sectors still waiting for a write-back
    always_comb begin
        pend = held_d;
    end
endmodule

// File: rtl/cfs_tag_arb.sv
// Tag port arbiter. A snoop owns the port in every cycle it asks for it; the
// flush walk gets the port only otherwise and is told so through scan_gnt.
// Walk writes always carry an invalid, clean entry.
module cfs_tag_arb #(
    parameter int SECTORS = 2,
    parameter int IDX_W   = 4,
    parameter int WAY_W   = 1
) (
    input  logic               snp_req,
    input  logic               snp_we,
    input  logic [WAY_W-1:0]   snp_way,
    input  logic [IDX_W-1:0]   snp_idx,
    input  logic               snp_wvalid,
    input  logic [SECTORS-1:0] snp_wdirty,
    input  logic               scan_en,
    input  logic               scan_we,
    input  logic [WAY_W-1:0]   scan_way,
    input  logic [IDX_W-1:0]   scan_idx,
    output logic               scan_gnt,
    output logic               tag_en,
    output logic               tag_we,
    output logic [WAY_W-1:0]   tag_way,
    output logic [IDX_W-1:0]   tag_idx,
    output logic               tag_wvalid,
    output logic [SECTORS-1:0] tag_wdirty
);
    // Choose the port owner, snoop first
    always_comb begin
        scan_gnt = !snp_req;
        if (snp_req) begin
            tag_en     = 1'b1;
            tag_we     = snp_we;
            tag_way    = snp_way;
            tag_idx    = snp_idx;
            tag_wvalid = snp_wvalid;
            tag_wdirty = snp_wdirty;
        end else begin
            tag_en     = scan_en;
            tag_we     = scan_we;
            tag_way    = scan_way;
            tag_idx    = scan_idx;
            tag_wvalid = 1'b0;
            tag_wdirty = '0;
        end
    end
endmodule

// File: rtl/cfs_ctrl.sv
// Flush walk controller: owns the request flag and the per-line sequence
// read -> take entry -> sector write-backs -> invalidate. Any step that needs
// the tag port repeats until scan_gnt is high. Assumes co_ack has meaning
// only while co_req is high.
module cfs_ctrl #(
    parameter int SECTORS = 2,
    parameter int SEC_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_set,
    input  logic               scan_gnt,
    input  logic               co_ack,
    input  logic               walk_last,
    input  logic [SECTORS-1:0] pend,
    output logic               flush_req,
    output logic               scan_en,
    output logic               scan_we,
    output logic               walk_step,
    output logic               walk_clr,
    output logic               hold_load,
    output logic               hold_track,
    output logic               retire,
    output logic [SEC_W-1:0]   sec,
    output logic               co_req
);
    import cfs_pkg::*;

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECTORS - 1);

    walk_state_e state, nstate;
    logic        sec_clr, sec_inc, done, cur_dirty;

    // Next-state and strobe decode
    always_comb begin
        nstate     = state;
        scan_en    = 1'b0;
        scan_we    = 1'b0;
        walk_step  = 1'b0;
        walk_clr   = 1'b0;
        hold_load  = 1'b0;
        hold_track = 1'b0;
        retire     = 1'b0;
        co_req     = 1'b0;
        sec_clr    = 1'b0;
        sec_inc    = 1'b0;
        done       = 1'b0;
        cur_dirty  = pend[sec];
        case (state)
            WS_IDLE: begin
                if (flush_req) nstate = WS_READ;
            end
            WS_READ: begin
                scan_en = 1'b1;
                if (scan_gnt) nstate = WS_CAPT;
            end
            WS_CAPT: begin
                hold_load  = 1'b1;
                hold_track = 1'b1;
                sec_clr    = 1'b1;
                nstate     = WS_CAST;
            end
            WS_CAST: begin
                hold_track = 1'b1;
                co_req     = cur_dirty;
                if (!cur_dirty || co_ack) begin
                    retire = cur_dirty;
                    if (sec == SEC_LAST) nstate = WS_INVAL;
                    else                 sec_inc = 1'b1;
                end
            end
            WS_INVAL: begin
                scan_en = 1'b1;
                scan_we = 1'b1;
                if (scan_gnt) begin
                    if (walk_last) begin
                        done     = 1'b1;
                        walk_clr = 1'b1;
                        nstate   = WS_IDLE;
                    end else begin
                        walk_step = 1'b1;
                        nstate    = WS_READ;
                    end
                end
            end
            default: nstate = WS_IDLE;
        endcase
    end

    // State and sector registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WS_IDLE;
            sec   <= '0;
        end else begin
            state <= nstate;
            if (sec_clr)      sec <= '0;
            else if (sec_inc) sec <= sec + 1'b1;
        end
    end

    // Request flag: hardware clear wins over a set in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)         flush_req <= 1'b0;
        else if (done)      flush_req <= 1'b0;
        else if (flush_set) flush_req <= 1'b1;
    end
endmodule

// File: rtl/cache_flush_sequencer.sv
// Top of the cache flush sequencer. Joins the controller, the line pointer,
// the working line copy and the tag port arbiter. Assumes a tag store that
// returns read data one cycle after an enabled read, and snoop writes that
// only clean or invalidate.
module cache_flush_sequencer #(
    parameter int IDX_W   = 4,
    parameter int WAYS    = 2,
    parameter int SECTORS = 2,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SEC_W  = (SECTORS > 1) ? $clog2(SECTORS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_set,
    output logic               flush_req,
    output logic               core_block,
    input  logic               snp_req,
    input  logic               snp_we,
    input  logic [WAY_W-1:0]   snp_way,
    input  logic [IDX_W-1:0]   snp_idx,
    input  logic               snp_wvalid,
    input  logic [SECTORS-1:0] snp_wdirty,
    output logic               tag_en,
    output logic               tag_we,
    output logic [WAY_W-1:0]   tag_way,
    output logic [IDX_W-1:0]   tag_idx,
    output logic               tag_wvalid,
    output logic [SECTORS-1:0] tag_wdirty,
    input  logic               tag_rvalid,
    input  logic [SECTORS-1:0] tag_rdirty,
    output logic               co_req,
    output logic [WAY_W-1:0]   co_way,
    output logic [IDX_W-1:0]   co_idx,
    output logic [SEC_W-1:0]   co_sec,
    input  logic               co_ack
);
    logic               scan_en, scan_we, scan_gnt;
    logic               walk_step, walk_clr, walk_last;
    logic               hold_load, hold_track, retire;
    logic [SEC_W-1:0]   sec;
    logic [SECTORS-1:0] pend;
    logic [IDX_W-1:0]   cur_idx;
    logic [WAY_W-1:0]   cur_way;

    cfs_ctrl #(.SECTORS(SECTORS), .SEC_W(SEC_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush_set(flush_set), .scan_gnt(scan_gnt),
        .co_ack(co_ack), .walk_last(walk_last), .pend(pend),
        .flush_req(flush_req), .scan_en(scan_en), .scan_we(scan_we),
        .walk_step(walk_step), .walk_clr(walk_clr), .hold_load(hold_load),
        .hold_track(hold_track), .retire(retire), .sec(sec), .co_req(co_req)
    );

    cfs_walk_counter #(.IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr(walk_clr), .step(walk_step),
        .idx(cur_idx), .way(cur_way), .last(walk_last)
    );

    cfs_line_hold #(.SECTORS(SECTORS), .IDX_W(IDX_W), .WAY_W(WAY_W), .SEC_W(SEC_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(hold_load), .ld_valid(tag_rvalid),
        .ld_dirty(tag_rdirty), .retire(retire), .retire_sec(sec),
        .track(hold_track), .cur_way(cur_way), .cur_idx(cur_idx),
        .snp_req(snp_req), .snp_we(snp_we), .snp_way(snp_way), .snp_idx(snp_idx),
        .snp_wvalid(snp_wvalid), .snp_wdirty(snp_wdirty), .pend(pend)
    );

    cfs_tag_arb #(.SECTORS(SECTORS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_arb (
        .snp_req(snp_req), .snp_we(snp_we), .snp_way(snp_way), .snp_idx(snp_idx),
        .snp_wvalid(snp_wvalid), .snp_wdirty(snp_wdirty),
        .scan_en(scan_en), .scan_we(scan_we), .scan_way(cur_way), .scan_idx(cur_idx),
        .scan_gnt(scan_gnt), .tag_en(tag_en), .tag_we(tag_we), .tag_way(tag_way),
        .tag_idx(tag_idx), .tag_wvalid(tag_wvalid), .tag_wdirty(tag_wdirty)
    );

    // Write-back address fields and core hold-off
    always_comb begin
        co_way     = cur_way;
        co_idx     = cur_idx;
        co_sec     = sec;
        core_block = flush_req;
    end
endmodule

// File: rtl/cfs_checker.sv
// Property checker for the cache flush sequencer, bound to every instance.
// Assumes the neighbour rules stated in the brief (one-cycle tag read,
// co_ack only with co_req, snoops never set dirty bits).
module cfs_checker #(
    parameter int IDX_W   = 4,
    parameter int SECTORS = 2,
    parameter int WAY_W   = 1,
    parameter int SEC_W   = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_set,
    input logic               flush_req,
    input logic               core_block,
    input logic               snp_req,
    input logic               snp_we,
    input logic [WAY_W-1:0]   snp_way,
    input logic [IDX_W-1:0]   snp_idx,
    input logic               tag_en,
    input logic               tag_we,
    input logic [WAY_W-1:0]   tag_way,
    input logic [IDX_W-1:0]   tag_idx,
    input logic               tag_wvalid,
    input logic [SECTORS-1:0] tag_wdirty,
    input logic               co_req,
    input logic [WAY_W-1:0]   co_way,
    input logic [IDX_W-1:0]   co_idx,
    input logic [SEC_W-1:0]   co_sec,
    input logic               co_ack
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!flush_req && !co_req));

    a_r2_flag_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(flush_set));

    a_r3_request_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (co_req && !co_ack && !snp_req) |=>
            (co_req && $stable(co_way) && $stable(co_idx) && $stable(co_sec)));

    a_r5_walk_writes_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_en && tag_we && !snp_req) |-> (!tag_wvalid && tag_wdirty == '0));

    a_r6_castout_only_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        co_req |-> (flush_req && core_block));

    a_r7_clear_after_inval: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flush_req) |-> $past(tag_en && tag_we && !tag_wvalid && !snp_req));

    a_r8_snoop_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
        snp_req |-> (tag_en && tag_we == snp_we && tag_way == snp_way && tag_idx == snp_idx));
endmodule

bind cache_flush_sequencer cfs_checker #(
    .IDX_W(IDX_W), .SECTORS(SECTORS), .WAY_W(WAY_W), .SEC_W(SEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush_set(flush_set), .flush_req(flush_req),
    .core_block(core_block), .snp_req(snp_req), .snp_we(snp_we),
    .snp_way(snp_way), .snp_idx(snp_idx), .tag_en(tag_en), .tag_we(tag_we),
    .tag_way(tag_way), .tag_idx(tag_idx), .tag_wvalid(tag_wvalid),
    .tag_wdirty(tag_wdirty), .co_req(co_req), .co_way(co_way), .co_idx(co_idx),
    .co_sec(co_sec), .co_ack(co_ack)
);

// File: tb/cache_flush_sequencer_bench.sv
// Self-checking bench: a tag store model, a random-delay write-back
// acknowledger, and whole-cache flushes over several tag patterns.
module cache_flush_sequencer_bench;
    localparam int IDX_W = 4;
    localparam int WAYS = 2;
    localparam int SECTORS = 2;
    localparam int NIDX = 1 << IDX_W;
    localparam int LINES = WAYS * NIDX;
    localparam int MAXCO = LINES * SECTORS;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, flush_set = 1'b0;
    logic flush_req, core_block;
    logic snp_req = 1'b0, snp_we = 1'b0, snp_wvalid = 1'b0;
    logic [0:0] snp_way = '0;
    logic [IDX_W-1:0] snp_idx = '0;
    logic [SECTORS-1:0] snp_wdirty = '0;
    logic tag_en, tag_we, tag_wvalid, tag_rvalid;
    logic [0:0] tag_way;
    logic [IDX_W-1:0] tag_idx;
    logic [SECTORS-1:0] tag_wdirty, tag_rdirty;
    logic co_req, co_ack;
    logic [0:0] co_way, co_sec;
    logic [IDX_W-1:0] co_idx;

    cache_flush_sequencer u_cache_flush_sequencer (
        .clk(clk), .rst_n(rst_n), .flush_set(flush_set), .flush_req(flush_req),
        .core_block(core_block), .snp_req(snp_req), .snp_we(snp_we),
        .snp_way(snp_way), .snp_idx(snp_idx), .snp_wvalid(snp_wvalid),
        .snp_wdirty(snp_wdirty), .tag_en(tag_en), .tag_we(tag_we),
        .tag_way(tag_way), .tag_idx(tag_idx), .tag_wvalid(tag_wvalid),
        .tag_wdirty(tag_wdirty), .tag_rvalid(tag_rvalid), .tag_rdirty(tag_rdirty),
        .co_req(co_req), .co_way(co_way), .co_idx(co_idx), .co_sec(co_sec),
        .co_ack(co_ack)
    );

    int total = 0, bad = 0;
    int blk_bad = 0;
    int ack_max = 0;
    int wait_n = 0;
    int got_n = 0, exp_n = 0;
    int got_way [0:MAXCO-1], got_idx [0:MAXCO-1], got_sec [0:MAXCO-1];
    int exp_way [0:MAXCO-1], exp_idx [0:MAXCO-1], exp_sec [0:MAXCO-1];

    // Store entries are {valid, dirty[1:0]}
    logic [2:0] mem [0:LINES-1];
    logic [2:0] ex  [0:LINES-1];
    logic [2:0] rd_q = '0;

    // Tag store model with one-cycle read latency
    always @(posedge clk) begin
        if (tag_en) begin
            if (tag_we) mem[{tag_way, tag_idx}] <= {tag_wvalid, tag_wdirty};
            else        rd_q <= mem[{tag_way, tag_idx}];
        end
    end
    assign tag_rvalid = rd_q[2];
    assign tag_rdirty = rd_q[1:0];

    // Write-back acknowledger with a random delay; records accepted requests
    always @(negedge clk) begin
        if (!rst_n) begin
            co_ack <= 1'b0;
            wait_n = 0;
        end else if (co_req) begin
            if (wait_n == 0) begin
                co_ack <= 1'b1;
                if (got_n < MAXCO) begin
                    got_way[got_n] = int'(co_way);
                    got_idx[got_n] = int'(co_idx);
                    got_sec[got_n] = int'(co_sec);
                end
                got_n++;
                wait_n = (ack_max == 0) ? 0 : int'($urandom_range(ack_max, 0));
            end else begin
                co_ack <= 1'b0;
                wait_n--;
            end
        end else begin
            co_ack <= 1'b0;
        end
    end

    // Hold-off monitor (R6)
    always @(negedge clk) begin
        if (rst_n && ((flush_req !== core_block) || (co_req && !flush_req))) blk_bad++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected write-back list from the pattern in ex
    task automatic build_expected();
        exp_n = 0;
        for (int w = 0; w < WAYS; w++)
            for (int i = 0; i < NIDX; i++)
                for (int s = 0; s < SECTORS; s++)
                    if (ex[w*NIDX+i][2] && ex[w*NIDX+i][s]) begin
                        exp_way[exp_n] = w;
                        exp_idx[exp_n] = i;
                        exp_sec[exp_n] = s;
                        exp_n++;
                    end
    endtask

    // One-cycle snoop through the block's port; checks the port takeover (R8)
    task automatic do_snoop(input int w, input int i, input bit we, input logic [2:0] v);
        @(negedge clk);
        snp_req = 1'b1; snp_we = we; snp_way = 1'(w); snp_idx = IDX_W'(i);
        snp_wvalid = v[2]; snp_wdirty = v[1:0];
        #1;
        chk(tag_en && tag_we == we && int'(tag_idx) == i && int'(tag_way) == w,
            "R8 snoop owns tag port", int'(tag_idx), i);
        @(negedge clk);
        snp_req = 1'b0; snp_we = 1'b0;
    endtask

    task automatic run_flush(input bit with_snp, input int amax);
        int sn_idx [0:5];
        int sn_op  [0:5];
        int cyc, mism, nv, hits, got_before;
        sn_idx = '{1, 3, 5, 8, 12, 15};
        sn_op  = '{1, 2, 0, 1, 2, 1};   // 0 read, 1 clean, 2 invalidate
        ack_max = amax;
        for (int k = 0; k < LINES; k++) ex[k] = mem[k];
        if (with_snp)
            for (int j = 0; j < 6; j++) begin
                if (sn_op[j] == 1) ex[NIDX + sn_idx[j]] = {ex[NIDX + sn_idx[j]][2], 2'b00};
                if (sn_op[j] == 2) ex[NIDX + sn_idx[j]] = 3'b000;
            end
        build_expected();
        got_n = 0;
        @(negedge clk); flush_set = 1'b1;
        @(negedge clk); flush_set = 1'b0;
        chk(flush_req == 1'b1, "R2 request flag set", int'(flush_req), 1);
        if (with_snp)
            for (int j = 0; j < 6; j++) begin
                repeat (5) @(negedge clk);
                do_snoop(0, j * 2, 1'b0, 3'b000);
                if (sn_op[j] == 0)
                    do_snoop(1, sn_idx[j], 1'b0, 3'b000);
                else if (sn_op[j] == 1)
                    do_snoop(1, sn_idx[j], 1'b1, {mem[NIDX + sn_idx[j]][2], 2'b00});
                else
                    do_snoop(1, sn_idx[j], 1'b1, 3'b000);
                if (j == 2) begin
                    @(negedge clk); flush_set = 1'b1;
                    @(negedge clk); flush_set = 1'b0;
                end
            end
        cyc = 0;
        while (flush_req && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(!flush_req, "R7 request flag self-clears", int'(flush_req), 0);
        got_before = got_n;
        repeat (20) @(negedge clk);
        chk(!flush_req && got_n == got_before, "R10 no second walk", got_n, got_before);
        chk(got_n == exp_n, "R3 write-back count", got_n, exp_n);
        mism = -1;
        for (int k = 0; k < exp_n && k < got_n; k++)
            if (mism < 0 && (got_way[k] != exp_way[k] || got_idx[k] != exp_idx[k] ||
                             got_sec[k] != exp_sec[k])) mism = k;
        chk(mism < 0, "R2 write-back order (first bad slot)", mism, -1);
        nv = 0;
        for (int k = 0; k < LINES; k++) if (mem[k] != 3'b000) nv++;
        chk(nv == 0, "R5 lines left non-zero", nv, 0);
        if (with_snp) begin
            hits = 0;
            for (int k = 0; k < got_n && k < MAXCO; k++)
                for (int j = 0; j < 6; j++)
                    if (sn_op[j] != 0 && got_way[k] == 1 && got_idx[k] == sn_idx[j]) hits++;
            chk(hits == 0, "R9 write-backs of snooped lines", hits, 0);
        end
    endtask

    // Global watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < LINES; k++) mem[k] = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!flush_req, "R1 flag after reset", int'(flush_req), 0);
        chk(!core_block, "R1 hold-off after reset", int'(core_block), 0);
        chk(!co_req, "R1 no request after reset", int'(co_req), 0);
        chk(!tag_en, "R1 tag port idle after reset", int'(tag_en), 0);

        // All lines empty: no write-backs (R4)
        run_flush(1'b0, 2);
        chk(got_n == 0, "R4 empty cache write-backs", got_n, 0);

        // Every sector dirty, immediate acknowledge
        for (int k = 0; k < LINES; k++) mem[k] = 3'b111;
        run_flush(1'b0, 0);

        // Valid-clean and invalid-with-dirty-bits lines: no write-backs (R4)
        for (int k = 0; k < LINES; k++) mem[k] = (k % 2 == 0) ? 3'b100 : 3'b011;
        run_flush(1'b0, 1);
        chk(got_n == 0, "R4 clean or invalid write-backs", got_n, 0);

        // Random patterns
        for (int t = 0; t < 3; t++) begin
            for (int k = 0; k < LINES; k++) mem[k] = 3'($urandom_range(7, 0));
            run_flush(1'b0, 3);
        end

        // Random pattern with snoops and a set pulse mid-flush
        for (int t = 0; t < 2; t++) begin
            for (int k = 0; k < LINES; k++) mem[k] = 3'($urandom_range(7, 0));
            for (int j = 0; j < NIDX; j++) mem[NIDX + j] = 3'b111;
            run_flush(1'b1, 2);
        end

        chk(blk_bad == 0, "R6 hold-off mismatches", blk_bad, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule